// File: doc/BRIEF.md
# Requester ID to Stream ID Translation Table

This block holds a small, fully associative table that turns the requester ID of an upstream transaction into the stream ID used by an address translation unit. Each slot is one 32-bit word. The word holds a valid flag, a stream ID and the requester ID to match. Software loads a slot with one write and reads it back through a simple register port. A write is complete once a read of the same slot returns the written value. Writing zero to a slot retires it.

The lookup side compares an incoming requester ID against every valid slot at once. It returns the stream ID of the lowest-numbered matching slot, together with a hit flag, one cycle later. When no valid slot matches, a one-cycle mapping error event is raised instead. The number of implemented slots is a parameter of at most 64. The remaining slot addresses read as zero and drop writes, so software can find the table size by writing a test pattern and checking whether it reads back.

Top module: `rid_sid_map`

## Requirements
- R1: An entry word carries the valid flag in bit 31, the stream ID in bits 30:16 and the requester ID in bits 15:0. Within the requester ID, the bus number is in bits 15:8, the device in bits 7:3 and the function in bits 2:0.
- R2: A write to an implemented slot (index below `N_ENT`) is visible on `rd_data_o` for that index in the cycle after the write edge, with the full 32-bit value.
- R3: Slot indices at or above `N_ENT` always read zero, and writes to them change nothing.
- R4: After reset every implemented slot reads zero, and every lookup misses, including a lookup of requester ID zero.
- R5: A lookup presented with `lk_valid_i` at a clock edge produces its result in the following cycle, with `lk_valid_o` high for exactly that cycle.
- R6: A lookup whose requester ID equals that of a valid slot returns `lk_hit_o`=1 and that slot's stream ID on `lk_sid_o`.
- R7: When several valid slots hold the same requester ID, the stream ID of the lowest-indexed one is returned.
- R8: A slot with bit 31 clear never matches. Writing zero to a slot removes its mapping, and a later lookup falls through to the next matching slot or misses.
- R9: A lookup that matches no valid slot drives `map_err_o`=1, `lk_hit_o`=0 and `lk_sid_o`=0 in the result cycle.
- R10: `lk_hit_o` and `map_err_o` are never high together, and both are low whenever `lk_valid_o` is low.
- R11: A lookup in the same cycle as a write sees the table as it was before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Slot write strobe |
| wr_idx_i | input | 6 | Slot index for the write |
| wr_data_i | input | 32 | Entry word to write |
| rd_idx_i | input | 6 | Slot index for the read |
| rd_data_o | output | 32 | Entry word at `rd_idx_i`, or zero if that slot is not implemented |
| lk_valid_i | input | 1 | Lookup request |
| lk_rid_i | input | 16 | Requester ID to translate |
| lk_valid_o | output | 1 | Lookup result valid |
| lk_hit_o | output | 1 | A valid slot matched |
| lk_sid_o | output | 15 | Stream ID of the winning slot, or zero on a miss |
| map_err_o | output | 1 | Mapping error event: the lookup missed |

## Verification
The assertions check on every cycle that:
- the result follows its request by exactly one cycle;
- hit and error are exclusive and silent when no lookup is active;
- any match among the per-slot compare lines turns into a hit, and the absence of any match turns into an error with a zero stream ID;
- unimplemented slots read zero;
- a write to an implemented slot reads back on the next cycle.

Only the bench scenarios can show that the correct stream ID is chosen when several slots match, that a retired slot lets the lookup fall through to a later duplicate, that the reset table misses requester ID zero, and that a write and a lookup in the same cycle give the old mapping.

// File: rtl/rsm_pkg.sv
package rsm_pkg;
  localparam int SLOT_CNT  = 64;
  localparam int IDX_W     = $clog2(SLOT_CNT);
  localparam int WORD_W    = 32;
  localparam int RID_W     = 16;
  localparam int SID_LSB   = 16;
  localparam int SID_W     = 15;
  localparam int VALID_BIT = 31;

  typedef logic [WORD_W-1:0] entry_t;

  function automatic logic ent_valid(entry_t e);
    return e[VALID_BIT];
  endfunction

  function automatic logic [SID_W-1:0] ent_sid(entry_t e);
    return e[SID_LSB +: SID_W];
  endfunction

  function automatic logic [RID_W-1:0] ent_rid(entry_t e);
    return e[RID_W-1:0];
  endfunction
endpackage

// File: rtl/rsm_entry_bank.sv
module rsm_entry_bank
  import rsm_pkg::*;
#(
  parameter int N_ENT = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [IDX_W-1:0]        wr_idx_i,
  input  entry_t                  wr_data_i,
  input  logic [IDX_W-1:0]        rd_idx_i,
  output entry_t                  rd_data_o,
  output logic [N_ENT-1:0][WORD_W-1:0] ent_o
);
  for (genvar i = 0; i < N_ENT; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  ent_o[i] <= '0;
      else if (wr_en_i && wr_idx_i == IDX_W'(i))    ent_o[i] <= wr_data_i;
    end
  end

  // unimplemented indices fall through to zero
  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < N_ENT; i++)
      if (rd_idx_i == IDX_W'(i)) rd_data_o = ent_o[i];
  end
endmodule

// File: rtl/rsm_match.sv
module rsm_match
  import rsm_pkg::*;
#(
  parameter int N_ENT = 16
) (
  input  logic [N_ENT-1:0][WORD_W-1:0] ent_i,
  input  logic [RID_W-1:0]             rid_i,
  output logic [N_ENT-1:0]             hit_vec_o,
  output logic                         any_hit_o,
  output logic [SID_W-1:0]             sid_o
);
  for (genvar i = 0; i < N_ENT; i++) begin : g_cmp
    assign hit_vec_o[i] = ent_valid(ent_i[i]) && (ent_rid(ent_i[i]) == rid_i);
  end

  assign any_hit_o = |hit_vec_o;

  // scan downward so the lowest index is written last
  always_comb begin
    sid_o = '0;
    for (int i = N_ENT - 1; i >= 0; i--)
      if (hit_vec_o[i]) sid_o = ent_sid(ent_i[i]);
  end
endmodule

// File: rtl/rid_sid_map.sv
module rid_sid_map
  import rsm_pkg::*;
#(
  parameter int N_ENT = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [IDX_W-1:0]     wr_idx_i,
  input  logic [WORD_W-1:0]    wr_data_i,
  input  logic [IDX_W-1:0]     rd_idx_i,
  output logic [WORD_W-1:0]    rd_data_o,
  input  logic                 lk_valid_i,
  input  logic [RID_W-1:0]     lk_rid_i,
  output logic                 lk_valid_o,
  output logic                 lk_hit_o,
  output logic [SID_W-1:0]     lk_sid_o,
  output logic                 map_err_o
);
  logic [N_ENT-1:0][WORD_W-1:0] ent;
  logic [N_ENT-1:0]             hit_vec;
  logic                         any_hit;
  logic [SID_W-1:0]             sid_c;

  rsm_entry_bank #(.N_ENT(N_ENT)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_idx_i  (wr_idx_i),
    .wr_data_i (wr_data_i),
    .rd_idx_i  (rd_idx_i),
    .rd_data_o (rd_data_o),
    .ent_o     (ent)
  );

  rsm_match #(.N_ENT(N_ENT)) u_match (
    .ent_i     (ent),
    .rid_i     (lk_rid_i),
    .hit_vec_o (hit_vec),
    .any_hit_o (any_hit),
    .sid_o     (sid_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lk_valid_o <= 1'b0;
      lk_hit_o   <= 1'b0;
      lk_sid_o   <= '0;
      map_err_o  <= 1'b0;
    end else begin
      lk_valid_o <= lk_valid_i;
      lk_hit_o   <= lk_valid_i && any_hit;
      lk_sid_o   <= (lk_valid_i && any_hit) ? sid_c : '0;
      map_err_o  <= lk_valid_i && !any_hit;
    end
  end
endmodule

// File: rtl/rid_sid_map_chk.sv
module rid_sid_map_chk
  import rsm_pkg::*;
#(
  parameter int N_ENT = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [IDX_W-1:0]  wr_idx_i,
  input logic [WORD_W-1:0] wr_data_i,
  input logic [IDX_W-1:0]  rd_idx_i,
  input logic [WORD_W-1:0] rd_data_o,
  input logic              lk_valid_i,
  input logic              lk_valid_o,
  input logic              lk_hit_o,
  input logic [SID_W-1:0]  lk_sid_o,
  input logic              map_err_o,
  input logic [N_ENT-1:0]  hit_vec
);
  localparam logic [IDX_W:0] N_LIM = (IDX_W+1)'(N_ENT);

  p_latency_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> lk_valid_o == $past(lk_valid_i));

  p_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lk_hit_o && map_err_o));

  p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_valid_o |-> !lk_hit_o && !map_err_o);

  p_hit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i && (|hit_vec) |=> lk_hit_o);

  p_miss_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i && !(|hit_vec) |=> map_err_o && lk_sid_o == '0);

  p_raz_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, rd_idx_i} >= N_LIM |-> rd_data_o == '0);

  p_readback_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && ({1'b0, wr_idx_i} < N_LIM) |=>
      (rd_idx_i != $past(wr_idx_i)) || (rd_data_o == $past(wr_data_i)));
endmodule

bind rid_sid_map rid_sid_map_chk #(.N_ENT(N_ENT)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .wr_idx_i   (wr_idx_i),
  .wr_data_i  (wr_data_i),
  .rd_idx_i   (rd_idx_i),
  .rd_data_o  (rd_data_o),
  .lk_valid_i (lk_valid_i),
  .lk_valid_o (lk_valid_o),
  .lk_hit_o   (lk_hit_o),
  .lk_sid_o   (lk_sid_o),
  .map_err_o  (map_err_o),
  .hit_vec    (hit_vec)
);

// File: tb/rid_sid_map_tb_top.sv
module rid_sid_map_tb_top;
  localparam int N_ENT = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic [5:0]  rd_idx = '0;
  logic [31:0] rd_data;
  logic        lk_vi = 1'b0;
  logic [15:0] lk_rid = '0;
  logic        lk_vo, lk_hit, map_err;
  logic [14:0] lk_sid;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  rid_sid_map #(.N_ENT(N_ENT)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .rd_idx_i(rd_idx), .rd_data_o(rd_data),
    .lk_valid_i(lk_vi), .lk_rid_i(lk_rid),
    .lk_valid_o(lk_vo), .lk_hit_o(lk_hit), .lk_sid_o(lk_sid), .map_err_o(map_err)
  );

  // lookup vectors: {rid[15:0], exp_hit, exp_sid[14:0]}
  localparam logic [31:0] LK_VEC [7] = '{
    {16'h0100, 1'b1, 15'h0011},  // bus 1 dev 0 fn 0
    {16'h0208, 1'b1, 15'h0022},  // bus 2 dev 1 fn 0, duplicate in slot 3
    {16'h0300, 1'b0, 15'h0000},  // slot 2 holds it, invalid
    {16'hffff, 1'b1, 15'h7fff},  // top slot, all-ones fields
    {16'h1234, 1'b0, 15'h0000},
    {16'h0000, 1'b0, 15'h0000},  // zero rid must not hit cleared slots
    {16'h0107, 1'b1, 15'h0055}   // bus 1 dev 0 fn 7
  };

  function automatic logic [31:0] mk(logic v, logic [14:0] sid, logic [7:0] bus,
                                     logic [4:0] dev, logic [2:0] fn);
    return {v, sid, bus, dev, fn};
  endfunction

  task automatic chk(logic ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] i, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_idx = i; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_chk(logic [5:0] i, logic [31:0] exp, string tag);
    rd_idx = i; #1;
    chk(rd_data == exp, tag, rd_data, exp);
  endtask

  task automatic lk_chk(logic [15:0] rid, logic eh, logic [14:0] es, string tag);
    @(negedge clk); lk_vi = 1'b1; lk_rid = rid;
    @(negedge clk); lk_vi = 1'b0;
    chk(lk_vo && lk_hit == eh && map_err == !eh && lk_sid == es, tag,
        {lk_vo, lk_hit, map_err, 14'd0, lk_sid}, {1'b1, eh, !eh, 14'd0, es});
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=%h exp=%h", 32'd1, 32'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R4: reset state
    rd_chk(6'd0, 32'h0, "R4 slot0 after reset");
    rd_chk(6'd15, 32'h0, "R4 slot15 after reset");
    chk(!lk_vo && !lk_hit && !map_err, "R10 idle after reset",
        {29'd0, lk_vo, lk_hit, map_err}, 32'h0);
    lk_chk(16'h0000, 1'b0, 15'h0, "R4 rid0 misses on empty table");

    // R1 packing: bus/dev/fn and sid fields
    wr(6'd0,  mk(1'b1, 15'h0011, 8'h01, 5'd0, 3'd0));
    wr(6'd1,  mk(1'b1, 15'h0022, 8'h02, 5'd1, 3'd0));
    wr(6'd2,  mk(1'b0, 15'h0033, 8'h03, 5'd0, 3'd0));
    wr(6'd3,  mk(1'b1, 15'h0044, 8'h02, 5'd1, 3'd0));
    wr(6'd4,  mk(1'b1, 15'h0055, 8'h01, 5'd0, 3'd7));
    wr(6'd15, mk(1'b1, 15'h7fff, 8'hff, 5'd31, 3'd7));
    rd_chk(6'd1, 32'h8022_0208, "R2 R1 slot1 readback");
    rd_chk(6'd15, 32'hffff_ffff, "R2 slot15 readback");

    for (int k = 0; k < 7; k++)
      lk_chk(LK_VEC[k][31:16], LK_VEC[k][15], LK_VEC[k][14:0],
             $sformatf("R6 R7 R9 vector %0d", k));

    // R3: unimplemented slots
    wr(6'd16, 32'h000b_ad1d);
    rd_chk(6'd16, 32'h0, "R3 slot16 write ignored");
    wr(6'd63, 32'hdead_beef);
    rd_chk(6'd63, 32'h0, "R3 slot63 write ignored");
    rd_chk(6'd0, 32'h8011_0100, "R3 slot0 unchanged by slot16 write");
    wr(6'd15, 32'h000b_ad1d);
    rd_chk(6'd15, 32'h000b_ad1d, "R2 pattern readback at last slot");

    // R8: invalidate slot1, lookup falls through to slot3
    wr(6'd1, 32'h0);
    rd_chk(6'd1, 32'h0, "R8 slot1 cleared");
    lk_chk(16'h0208, 1'b1, 15'h0044, "R8 R7 fall through to slot3");
    wr(6'd3, 32'h0);
    lk_chk(16'h0208, 1'b0, 15'h0, "R8 R9 all copies retired");

    // R11: write and lookup in the same cycle
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 6'd5; wr_data = mk(1'b1, 15'h0066, 8'h09, 5'd2, 3'd1);
    lk_vi = 1'b1; lk_rid = 16'h0911;
    @(negedge clk);
    wr_en = 1'b0; lk_vi = 1'b0;
    chk(lk_vo && !lk_hit && map_err, "R11 same-cycle lookup sees old table",
        {29'd0, lk_vo, lk_hit, map_err}, 32'h5);
    lk_chk(16'h0911, 1'b1, 15'h0066, "R11 R6 next lookup sees new entry");

    // R5: result lasts one cycle
    @(negedge clk);
    chk(!lk_vo && !lk_hit && !map_err, "R5 R10 result drops after one cycle",
        {29'd0, lk_vo, lk_hit, map_err}, 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule